// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the coherence engine for a small direct-mapped private cache on a shared-bus multiprocessor. It stores a tag, a coherence state and one data word per line. It serves read and write requests from its own processor. When a request needs the bus, it issues a read, a read-with-invalidate, a write-through, a write-back or an invalidate, and then waits for the bus to acknowledge.

Coherence follows a write-once policy. The first write to a clean shared line is sent through to memory, and the line becomes Reserved: written exactly once and still equal to memory. Any later write stays in the cache, and the line becomes Dirty. Every local write removes copies of the line held by other caches.

In parallel with its own work, the block watches the transactions that other caches place on the bus. For each one it reports whether it owns the line and, when another cache reads a line that is Dirty here, it supplies the data. After each snooped transaction it demotes or invalidates its own copy as the policy requires. Bus arbitration, memory and the other caches are outside the block.

Top module: `wonce_cache`

## Requirements
- R1: After reset every line is Invalid, and `cpuReady` and `busReq` are low. The first read of any address therefore misses and issues a bus READ.
- R2: A read hit in Valid, Reserved or Dirty raises `cpuReady` for exactly one cycle, one clock after the request is accepted, and makes no bus request.
- R3: A read miss issues busCmd READ (code 1) at the request address. When `busAck` arrives, the line is filled from `busRdata` in state Valid and that word is returned on `cpuRdata`. Command, address and data stay stable until the acknowledge.
- R4: A write hit on a Valid line issues WRITE (code 3), carrying the address and the write data, and leaves the line Reserved.
- R5: A write hit on a Reserved or Dirty line issues INVAL (code 5) and sends no data to memory. The line becomes Dirty and holds the new data.
- R6: A write miss issues READX (code 2) and leaves the line Dirty, holding the processor's data.
- R7: A miss that evicts a Dirty line first issues WRBACK (code 4) with the victim's address and data, and then issues the fill command. A miss that evicts a Valid or Reserved line issues only the fill command.
- R8: A snooped READ (1) or READX (2) that hits a Dirty line raises `snpFlush` and `snpOwned` in the same cycle, with the line's data on `snpData`. After a READ the line is Valid.
- R9: A snooped READ that hits a Reserved line raises `snpOwned` but not `snpFlush`, and the line becomes Valid.
- R10: A snooped READX, WRITE or INVAL whose address matches a line forces that line to Invalid, whatever state it was in.
- R11: A snoop whose tag does not match, a snooped WRBACK, or any snoop with `snpValid` low leaves the line state unchanged. `snpOwned` is high only for a valid snoop that matches a Reserved or Dirty line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the request |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` |
| busReq | output | 1 | Bus transaction pending |
| busCmd | output | 3 | 1 READ, 2 READX, 3 WRITE, 4 WRBACK, 5 INVAL, 0 none |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Data for WRITE and WRBACK |
| busAck | input | 1 | One-cycle completion of the pending transaction |
| busRdata | input | DATA_W | Fill data, valid with `busAck` |
| snpValid | input | 1 | A foreign bus transaction is present |
| snpCmd | input | 3 | Command of the foreign transaction, same codes |
| snpAddr | input | ADDR_W | Address of the foreign transaction |
| snpOwned | output | 1 | Matching line is Reserved or Dirty |
| snpFlush | output | 1 | This cache supplies Dirty data |
| snpData | output | DATA_W | Data supplied on a flush |

## Verification
A read hit raises `cpuReady` one clock after the edge that accepts the request. Any operation that uses the bus raises `cpuReady` one clock after the edge that samples `busAck`. The snoop outputs are combinational in the same cycle as the snoop, and the resulting state change takes effect at the next edge. The bench drives and samples on falling edges and counts the falling edges between a request and its ready pulse, so hit latency is checked exactly. Line states are inferred from later behaviour: which command the next write issues, whether a read touches the bus, and what a harmless snooped WRBACK reports on `snpOwned`.

// File: rtl/wonce_pkg.sv
package wonce_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_RSV = 2'd2,
    LS_DRT = 2'd3
  } lineState_e;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_READ   = 3'd1,
    BC_READX  = 3'd2,
    BC_WRITE  = 3'd3,
    BC_WRBACK = 3'd4,
    BC_INVAL  = 3'd5
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capReq;       // latch processor address and data
    logic       capHitData;   // load response register from the array
    logic       capBusData;   // load response register from the bus
    logic       lineWr;       // write tag, state and data at request index
    lineState_e newState;     // state written with lineWr
    logic       dataFromBus;  // line data comes from busRdata
    logic       addrVictim;   // bus carries the victim line
  } dpStrobe_t;

endpackage

// File: rtl/wonce_datapath.sv
module wonce_datapath
  import wonce_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              liveHit,
  output lineState_e        liveState,
  output logic              liveVictimDirty,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              snpOwned,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  lineState_e        stateArr [LINES];
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] rdataReg;

  logic [INDEX_W-1:0] cpuIdx, reqIdx, snpIdx;
  logic [TAG_W-1:0]   cpuTag, reqTag, snpTag;

  assign cpuIdx = cpuAddr[INDEX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign reqIdx = reqAddr[INDEX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:INDEX_W];
  assign snpIdx = snpAddr[INDEX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:INDEX_W];

  // lookup for the live processor request
  assign liveState       = stateArr[cpuIdx];
  assign liveHit         = (stateArr[cpuIdx] != LS_INV) && (tagArr[cpuIdx] == cpuTag);
  assign liveVictimDirty = (stateArr[cpuIdx] == LS_DRT);

  // bus address and data: victim line or latched request
  assign busAddr  = strobe.addrVictim ? {tagArr[reqIdx], reqIdx} : reqAddr;
  assign busWdata = strobe.addrVictim ? dataArr[reqIdx] : reqWdata;
  assign cpuRdata = rdataReg;

  // snoop reaction for one line
  function automatic lineState_e snoopNext(input lineState_e cur, input logic hit,
                                           input logic [2:0] cmd);
    lineState_e nxt;
    nxt = cur;
    if (hit) begin
      case (cmd)
        BC_READ:                     nxt = (cur == LS_INV) ? LS_INV : LS_VAL;
        BC_READX, BC_WRITE, BC_INVAL: nxt = LS_INV;
        default:                     nxt = cur;
      endcase
    end
    return nxt;
  endfunction

  logic [LINES-1:0]       snpSel;
  lineState_e [LINES-1:0] snpNext;

  for (genvar g = 0; g < LINES; g++) begin : g_snoop
    assign snpSel[g]  = snpValid && (snpIdx == INDEX_W'(g)) &&
                        (stateArr[g] != LS_INV) && (tagArr[g] == snpTag);
    assign snpNext[g] = snoopNext(stateArr[g], snpSel[g], snpCmd);
  end

  logic snpMatch;
  assign snpMatch = |snpSel;
  assign snpOwned = snpMatch && ((stateArr[snpIdx] == LS_RSV) || (stateArr[snpIdx] == LS_DRT));
  assign snpFlush = snpMatch && (stateArr[snpIdx] == LS_DRT) &&
                    ((snpCmd == BC_READ) || (snpCmd == BC_READX));
  assign snpData  = dataArr[snpIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      rdataReg <= '0;
      for (int i = 0; i < LINES; i++) begin
        stateArr[i] <= LS_INV;
        tagArr[i]   <= '0;
        dataArr[i]  <= '0;
      end
    end else begin
      if (strobe.capReq) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
      end
      if (strobe.capHitData)      rdataReg <= dataArr[cpuIdx];
      else if (strobe.capBusData) rdataReg <= busRdata;
      // local completion takes priority over a snoop on the same line
      for (int i = 0; i < LINES; i++) begin
        if (strobe.lineWr && (reqIdx == INDEX_W'(i))) begin
          stateArr[i] <= strobe.newState;
          tagArr[i]   <= reqTag;
          dataArr[i]  <= strobe.dataFromBus ? busRdata : reqWdata;
        end else begin
          stateArr[i] <= snpNext[i];
        end
      end
    end
  end

endmodule

// File: rtl/wonce_control.sv
module wonce_control
  import wonce_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       liveHit,
  input  lineState_e liveState,
  input  logic       liveVictimDirty,
  input  logic       busAck,
  output dpStrobe_t  strobe,
  output logic       busReq,
  output logic [2:0] busCmd,
  output logic       cpuReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_XACT, ST_RESP} fsm_e;

  fsm_e       fsm, fsmNext;
  busCmd_e    cmdReg, cmdNext;
  lineState_e endState, endStateNext;
  logic       fromBus, fromBusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm      <= ST_IDLE;
      cmdReg   <= BC_NONE;
      endState <= LS_INV;
      fromBus  <= 1'b0;
    end else begin
      fsm      <= fsmNext;
      cmdReg   <= cmdNext;
      endState <= endStateNext;
      fromBus  <= fromBusNext;
    end
  end

  always_comb begin
    fsmNext         = fsm;
    cmdNext         = cmdReg;
    endStateNext    = endState;
    fromBusNext     = fromBus;
    strobe          = '0;
    strobe.newState = endState;
    busReq          = 1'b0;
    busCmd          = BC_NONE;
    cpuReady        = 1'b0;
    case (fsm)
      ST_IDLE: begin
        if (cpuReq) begin
          strobe.capReq = 1'b1;
          if (liveHit && !cpuWe) begin
            strobe.capHitData = 1'b1;
            fsmNext           = ST_RESP;
          end else if (liveHit) begin
            // first write goes through, later writes only invalidate
            cmdNext      = (liveState == LS_VAL) ? BC_WRITE : BC_INVAL;
            endStateNext = (liveState == LS_VAL) ? LS_RSV : LS_DRT;
            fromBusNext  = 1'b0;
            fsmNext      = ST_XACT;
          end else begin
            cmdNext      = cpuWe ? BC_READX : BC_READ;
            endStateNext = cpuWe ? LS_DRT : LS_VAL;
            fromBusNext  = !cpuWe;
            fsmNext      = liveVictimDirty ? ST_WB : ST_XACT;
          end
        end
      end
      ST_WB: begin
        busReq            = 1'b1;
        busCmd            = BC_WRBACK;
        strobe.addrVictim = 1'b1;
        if (busAck) fsmNext = ST_XACT;
      end
      ST_XACT: begin
        busReq = 1'b1;
        busCmd = cmdReg;
        if (busAck) begin
          strobe.lineWr      = 1'b1;
          strobe.dataFromBus = fromBus;
          strobe.capBusData  = fromBus;
          fsmNext            = ST_RESP;
        end
      end
      ST_RESP: begin
        cpuReady = 1'b1;
        fsmNext  = ST_IDLE;
      end
      default: fsmNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wonce_cache.sv
module wonce_cache
  import wonce_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [2:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpOwned,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);

  dpStrobe_t  strobe;
  logic       liveHit;
  lineState_e liveState;
  logic       liveVictimDirty;

  wonce_control u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .cpuReq          (cpuReq),
    .cpuWe           (cpuWe),
    .liveHit         (liveHit),
    .liveState       (liveState),
    .liveVictimDirty (liveVictimDirty),
    .busAck          (busAck),
    .strobe          (strobe),
    .busReq          (busReq),
    .busCmd          (busCmd),
    .cpuReady        (cpuReady)
  );

  wonce_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INDEX_W (INDEX_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .cpuAddr         (cpuAddr),
    .cpuWdata        (cpuWdata),
    .strobe          (strobe),
    .busRdata        (busRdata),
    .snpValid        (snpValid),
    .snpCmd          (snpCmd),
    .snpAddr         (snpAddr),
    .liveHit         (liveHit),
    .liveState       (liveState),
    .liveVictimDirty (liveVictimDirty),
    .busAddr         (busAddr),
    .busWdata        (busWdata),
    .cpuRdata        (cpuRdata),
    .snpOwned        (snpOwned),
    .snpFlush        (snpFlush),
    .snpData         (snpData)
  );

endmodule

// File: rtl/wonce_checker.sv
module wonce_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              busReq,
  input logic [2:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck,
  input logic              snpValid,
  input logic [2:0]        snpCmd,
  input logic              snpOwned,
  input logic              snpFlush
);

  // R3
  holdReq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busCmd) && $stable(busAddr));

  // R2
  readyPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R2
  readyNoBus_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busReq);

  // R7
  wbThenFill_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && (busCmd == 3'd4) && busAck |=> busReq && ((busCmd == 3'd1) || (busCmd == 3'd2)));

  // R8
  flushOwned_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> snpOwned);

  // R8
  flushCmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> snpValid && ((snpCmd == 3'd1) || (snpCmd == 3'd2)));

  // R1
  cmdValid_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busCmd != 3'd0));

endmodule

bind wonce_cache wonce_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReady (cpuReady),
  .busReq   (busReq),
  .busCmd   (busCmd),
  .busAddr  (busAddr),
  .busAck   (busAck),
  .snpValid (snpValid),
  .snpCmd   (snpCmd),
  .snpOwned (snpOwned),
  .snpFlush (snpFlush)
);

// File: tb/wonce_cache_tb.sv
module wonce_cache_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam logic [2:0] C_READ = 3'd1, C_READX = 3'd2, C_WRITE = 3'd3,
                         C_WRBACK = 3'd4, C_INVAL = 3'd5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              cpuReq, cpuWe;
  logic [ADDR_W-1:0] cpuAddr;
  logic [DATA_W-1:0] cpuWdata;
  logic              cpuReady;
  logic [DATA_W-1:0] cpuRdata;
  logic              busReq;
  logic [2:0]        busCmd;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic              busAck;
  logic [DATA_W-1:0] busRdata;
  logic              snpValid;
  logic [2:0]        snpCmd;
  logic [ADDR_W-1:0] snpAddr;
  logic              snpOwned, snpFlush;
  logic [DATA_W-1:0] snpData;

  wonce_cache u_dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpOwned(snpOwned), .snpFlush(snpFlush), .snpData(snpData)
  );

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct packed {
    logic [2:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              chkData;
  } busItem_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              chk;
  } rspItem_t;

  busItem_t expBus[$];
  string    expBusReq[$];
  rspItem_t expRsp[$];
  string    expRspReq[$];

  logic [DATA_W-1:0] memModel [logic [ADDR_W-1:0]];

  function automatic logic [DATA_W-1:0] memRd(input logic [ADDR_W-1:0] a);
    if (memModel.exists(a)) return memModel[a];
    return {16'hA5A5, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expectBus(input logic [2:0] cmd, input logic [ADDR_W-1:0] addr,
                           input logic [DATA_W-1:0] data, input bit chkData, input string req);
    busItem_t it;
    it.cmd = cmd; it.addr = addr; it.data = data; it.chkData = chkData;
    expBus.push_back(it);
    expBusReq.push_back(req);
  endtask

  task automatic expectRsp(input logic [DATA_W-1:0] data, input bit chk, input string req);
    rspItem_t it;
    it.data = data; it.chk = chk;
    expRsp.push_back(it);
    expRspReq.push_back(req);
  endtask

  // bus responder and bus monitor
  initial begin
    busAck   = 1'b0;
    busRdata = '0;
    forever begin
      @(negedge clk);
      if (rstN && busReq) begin
        if (expBus.size() == 0) begin
          check(1'b0, "R2", "unexpected bus command", 32'(busCmd), 32'd0);
        end else begin
          busItem_t it;
          string r;
          it = expBus.pop_front();
          r  = expBusReq.pop_front();
          check(busCmd == it.cmd, r, "bus command", 32'(busCmd), 32'(it.cmd));
          check(busAddr == it.addr, r, "bus address", 32'(busAddr), 32'(it.addr));
          if (it.chkData) check(busWdata == it.data, r, "bus write data", busWdata, it.data);
        end
        @(negedge clk);
        busRdata = memRd(busAddr);
        if (busCmd == C_WRITE || busCmd == C_WRBACK) memModel[busAddr] = busWdata;
        busAck = 1'b1;
        @(negedge clk);
        busAck = 1'b0;
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && cpuReady) begin
        if (expRsp.size() == 0) begin
          check(1'b0, "R2", "unexpected response", 32'd1, 32'd0);
        end else begin
          rspItem_t it;
          string r;
          it = expRsp.pop_front();
          r  = expRspReq.pop_front();
          if (it.chk) check(cpuRdata == it.data, r, "read data", cpuRdata, it.data);
        end
      end
    end
  end

  task automatic cpuOp(input bit we, input logic [ADDR_W-1:0] addr,
                       input logic [DATA_W-1:0] wdata, input int expLat, input string req);
    int lat;
    lat = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpuReady && lat < 200);
    cpuReq = 1'b0;
    if (expLat > 0) check(lat == expLat, req, "response latency", 32'(lat), 32'(expLat));
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [ADDR_W-1:0] addr, input bit valid,
                       input bit expOwned, input bit expFlush, input logic [DATA_W-1:0] expData,
                       input string req);
    @(negedge clk);
    snpValid = valid; snpCmd = cmd; snpAddr = addr;
    #1;
    check(snpOwned == expOwned, req, "snoop owned", 32'(snpOwned), 32'(expOwned));
    check(snpFlush == expFlush, req, "snoop flush", 32'(snpFlush), 32'(expFlush));
    if (expFlush) check(snpData == expData, req, "snoop data", snpData, expData);
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  localparam logic [ADDR_W-1:0] A = 16'h0010, A2 = 16'h0110, B = 16'h0021,
                                C = 16'h0025, D = 16'h0030, E = 16'h0040;

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    snpValid = 1'b0; snpCmd = '0; snpAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReady == 1'b0, "R1", "ready after reset", 32'(cpuReady), 32'd0);
    check(busReq == 1'b0, "R1", "busReq after reset", 32'(busReq), 32'd0);

    // R1 / R3: cold read misses
    expectBus(C_READ, A, '0, 1'b0, "R1");
    expectRsp(memRd(A), 1'b1, "R3");
    cpuOp(1'b0, A, '0, 0, "R3");

    // R2: hit in Valid
    expectRsp(memRd(A), 1'b1, "R2");
    cpuOp(1'b0, A, '0, 1, "R2");
    snoop(C_WRBACK, A, 1'b1, 1'b0, 1'b0, '0, "R11");

    // R4: first write goes through, line Reserved
    expectBus(C_WRITE, A, 32'h1111_1111, 1'b1, "R4");
    expectRsp('0, 1'b0, "R4");
    cpuOp(1'b1, A, 32'h1111_1111, 0, "R4");
    snoop(C_WRBACK, A, 1'b1, 1'b1, 1'b0, '0, "R4");

    // R5: second write only invalidates, line Dirty
    expectBus(C_INVAL, A, '0, 1'b0, "R5");
    expectRsp('0, 1'b0, "R5");
    cpuOp(1'b1, A, 32'h2222_2222, 0, "R5");
    check(memRd(A) == 32'h1111_1111, "R5", "memory untouched", memRd(A), 32'h1111_1111);

    // R8: snooped read of Dirty line supplies data and demotes to Valid
    snoop(C_READ, A, 1'b1, 1'b1, 1'b1, 32'h2222_2222, "R8");
    expectRsp(32'h2222_2222, 1'b1, "R8");
    cpuOp(1'b0, A, '0, 1, "R8");
    snoop(C_WRBACK, A, 1'b1, 1'b0, 1'b0, '0, "R8");

    // Valid again: write goes through
    expectBus(C_WRITE, A, 32'h3333_3333, 1'b1, "R4");
    expectRsp('0, 1'b0, "R4");
    cpuOp(1'b1, A, 32'h3333_3333, 0, "R4");

    // R9: snooped read of Reserved line demotes to Valid without flush
    snoop(C_READ, A, 1'b1, 1'b1, 1'b0, '0, "R9");
    expectBus(C_WRITE, A, 32'h4444_4444, 1'b1, "R9");
    expectRsp('0, 1'b0, "R9");
    cpuOp(1'b1, A, 32'h4444_4444, 0, "R9");

    // R11: foreign tag on same index leaves the line alone
    snoop(C_READ, A2, 1'b1, 1'b0, 1'b0, '0, "R11");
    snoop(C_WRBACK, A, 1'b1, 1'b1, 1'b0, '0, "R11");

    // R10: snooped invalidate and write-through kill the line
    snoop(C_INVAL, A, 1'b1, 1'b1, 1'b0, '0, "R10");
    expectBus(C_READ, A, '0, 1'b0, "R10");
    expectRsp(32'h4444_4444, 1'b1, "R10");
    cpuOp(1'b0, A, '0, 0, "R10");
    snoop(C_WRITE, A, 1'b1, 1'b0, 1'b0, '0, "R10");
    expectBus(C_READ, A, '0, 1'b0, "R10");
    expectRsp(32'h4444_4444, 1'b1, "R10");
    cpuOp(1'b0, A, '0, 0, "R10");

    // R11: snpValid low has no effect
    snoop(C_INVAL, A, 1'b0, 1'b0, 1'b0, '0, "R11");
    expectRsp(32'h4444_4444, 1'b1, "R11");
    cpuOp(1'b0, A, '0, 1, "R11");

    // R6: write miss, read-with-invalidate, line Dirty
    expectBus(C_READX, B, '0, 1'b0, "R6");
    expectRsp('0, 1'b0, "R6");
    cpuOp(1'b1, B, 32'h5555_5555, 0, "R6");
    snoop(C_WRBACK, B, 1'b1, 1'b1, 1'b0, '0, "R6");
    expectBus(C_INVAL, B, '0, 1'b0, "R5");
    expectRsp('0, 1'b0, "R5");
    cpuOp(1'b1, B, 32'h6666_6666, 0, "R5");
    expectRsp(32'h6666_6666, 1'b1, "R6");
    cpuOp(1'b0, B, '0, 1, "R6");

    // R7: dirty victim written back before the fill
    expectBus(C_WRBACK, B, 32'h6666_6666, 1'b1, "R7");
    expectBus(C_READ, C, '0, 1'b0, "R7");
    expectRsp(memRd(C), 1'b1, "R7");
    cpuOp(1'b0, C, '0, 0, "R7");
    check(memRd(B) == 32'h6666_6666, "R7", "victim in memory", memRd(B), 32'h6666_6666);

    // R7: clean victims (Valid, then Reserved) need no write-back
    expectBus(C_READ, D, '0, 1'b0, "R7");
    expectRsp(memRd(D), 1'b1, "R7");
    cpuOp(1'b0, D, '0, 0, "R7");
    expectBus(C_WRITE, D, 32'h7777_7777, 1'b1, "R4");
    expectRsp('0, 1'b0, "R4");
    cpuOp(1'b1, D, 32'h7777_7777, 0, "R4");
    expectBus(C_READ, E, '0, 1'b0, "R7");
    expectRsp(memRd(E), 1'b1, "R7");
    cpuOp(1'b0, E, '0, 0, "R7");

    // R8 / R10: snooped READX on Dirty flushes and invalidates
    expectBus(C_WRITE, C, 32'h8888_8888, 1'b1, "R4");
    expectRsp('0, 1'b0, "R4");
    cpuOp(1'b1, C, 32'h8888_8888, 0, "R4");
    expectBus(C_INVAL, C, '0, 1'b0, "R5");
    expectRsp('0, 1'b0, "R5");
    cpuOp(1'b1, C, 32'h9999_9999, 0, "R5");
    snoop(C_READX, C, 1'b1, 1'b1, 1'b1, 32'h9999_9999, "R8");
    expectBus(C_READ, C, '0, 1'b0, "R10");
    expectRsp(32'h8888_8888, 1'b1, "R10");
    cpuOp(1'b0, C, '0, 0, "R10");

    repeat (4) @(negedge clk);
    check(expBus.size() == 0, "R2", "bus items left", 32'(expBus.size()), 32'd0);
    check(expRsp.size() == 0, "R2", "responses left", 32'(expRsp.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule